// File: doc/BRIEF.md
# Ethernet Receive Packet Filter

This block sits on the receive side of a 10/100 Ethernet port. It reads the media-independent nibble stream that comes from the PHY and gives one keep-or-drop decision for each frame. It runs directly in the receive clock domain, which is 2.5 MHz at 10 Mbps and 25 MHz at 100 Mbps. It takes one nibble per clock while the data-valid input is high.

The destination MAC address must equal the station address or one of a small set of enabled multicast entries. For IPv4 frames, a list of programmable rules is checked next. Each rule can compare the source or destination IP address and the TCP or UDP source or destination port. The lowest-numbered matching rule decides the result, either pass or drop. A frame that has a receive error, or that ends before the fields it needs, is always dropped. The result comes out as a single-cycle pulse after the frame ends, together with an error flag. Software programs the tables through a plain write port.

Top module: `eth_rx_filter`

## Requirements
- R1: After reset, `verdict_vld`, `verdict_pass` and `verdict_err` are low. No verdict is produced while `rx_dv` stays low.
- R2: Nibbles are paired into bytes with the low nibble first. Any number of preamble nibbles, zero or more, may precede the first 0xD nibble. The byte after that 0xD nibble is destination byte 0. A burst that never contains 0xD gets a drop verdict.
- R3: A frame whose destination (bytes 0..5, first byte most significant) equals the station address passes when its type field (bytes 12..13) is not 0x0800.
- R4: A destination equal to an enabled multicast entry is accepted at the MAC level. A disabled entry never matches.
- R5: A frame whose destination matches neither the station address nor an enabled multicast entry is dropped.
- R6: For every `rx_dv` burst, `verdict_vld` is high for exactly one cycle. It is registered at the second rising edge at which `rx_dv` is sampled low.
- R7: If `rx_er` is high in any cycle where `rx_dv` is high, the verdict has `verdict_err`=1 and `verdict_pass`=0. The flag is cleared for the next frame.
- R8: A frame is dropped if it has fewer than 14 bytes. An IPv4 frame is dropped if it has fewer than 34 bytes, or fewer than 38 bytes when the protocol byte (23) is 6 or 17.
- R9: An IPv4 rule can compare either the source IP (bytes 26..29) or the destination IP (bytes 30..33). When it matches, its action decides the verdict.
- R10: A port rule can compare either the source port (bytes 34..35) or the destination port (bytes 36..37). It matches only when the protocol is TCP (6) or UDP (17).
- R11: Of the enabled rules that match, the one with the lowest index decides. Disabled rules are ignored.
- R12: An IPv4 frame that matches no rule passes.
- R13: The write map is as follows. Word 0 holds station address bits 31..0, and word 1 holds bits 47..32. Multicast entry i uses word 2+2i for bits 31..0, and word 3+2i for bits 47..32 in [15:0] with the enable in bit 16. Rule j uses word 2+2N+3j for the IP value, the next word for the port in [15:0], and the word after that for control. Control bit 0 is enable, bit 1 is pass(1)/drop(0), bit 2 compares IP, bit 3 selects destination IP, bit 4 compares port, and bit 5 selects destination port. A write takes effect for the frames that follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error from the PHY |
| rx_nib | input | 4 | Receive data nibble |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | CFG_AW (5) | Table word address |
| cfg_wdata | input | 32 | Table write data |
| verdict_vld | output | 1 | One-cycle verdict pulse |
| verdict_pass | output | 1 | 1 = keep frame, 0 = drop |
| verdict_err | output | 1 | Frame had a receive error |

## Verification
The bench uses the default sizes of four multicast entries and four rules. With four rules it can program two rules that both match one frame but have opposite actions, so lowest-index priority is observable. The fourth rule can later be turned into a catch-all drop to change the default outcome. Two multicast entries, one enabled and one disabled, check the enable bit. The 6-bit byte counter reaches past the 38-byte port boundary, so frames ending at 13, 37 and 38 bytes test each length threshold.

// File: rtl/eth_rxf_pkg.sv
package eth_rxf_pkg;
  localparam logic [3:0]  SFD_NIB    = 4'hD;
  localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
  localparam logic [7:0]  PROTO_TCP  = 8'd6;
  localparam logic [7:0]  PROTO_UDP  = 8'd17;

  // byte offsets counted from the first destination byte
  localparam int OFS_DA     = 0;
  localparam int OFS_ETYPE  = 12;
  localparam int OFS_PROTO  = 23;
  localparam int OFS_SIP    = 26;
  localparam int OFS_DIP    = 30;
  localparam int OFS_SPORT  = 34;
  localparam int OFS_DPORT  = 36;

  // minimum lengths per parsing depth
  localparam int LEN_L2 = 14;
  localparam int LEN_L3 = 34;
  localparam int LEN_L4 = 38;

  typedef struct packed {
    logic port_dst;
    logic use_port;
    logic ip_dst;
    logic use_ip;
    logic act_pass;
    logic en;
  } rule_ctl_t;

  typedef struct packed {
    logic [47:0] da;
    logic [15:0] etype;
    logic [7:0]  proto;
    logic [31:0] sip;
    logic [31:0] dip;
    logic [15:0] sport;
    logic [15:0] dport;
  } hdr_t;
endpackage

// File: rtl/rxf_nib_asm.sv
module rxf_nib_asm
  import eth_rxf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_dv,
  input  logic       rx_er,
  input  logic [3:0] rx_nib,
  output logic       sof,
  output logic       eof,
  output logic       frm_err,
  output logic       byte_vld,
  output logic [7:0] byte_dat
);
  logic       dv_q;
  logic       in_data;
  logic       phase;
  logic [3:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dv_q     <= 1'b0;
      sof      <= 1'b0;
      eof      <= 1'b0;
      frm_err  <= 1'b0;
      in_data  <= 1'b0;
      phase    <= 1'b0;
      lo_q     <= '0;
      byte_vld <= 1'b0;
      byte_dat <= '0;
    end else begin
      dv_q     <= rx_dv;
      sof      <= rx_dv && !dv_q;
      eof      <= dv_q && !rx_dv;
      byte_vld <= 1'b0;
      if (rx_dv) begin
        if (!dv_q) begin
          frm_err <= rx_er;
          in_data <= (rx_nib == SFD_NIB);
          phase   <= 1'b0;
        end else begin
          if (rx_er) frm_err <= 1'b1;
          if (!in_data) begin
            in_data <= (rx_nib == SFD_NIB);
          end else begin
            phase <= ~phase;
            if (!phase) begin
              lo_q <= rx_nib;
            end else begin
              byte_vld <= 1'b1;
              byte_dat <= {rx_nib, lo_q};
            end
          end
        end
      end
    end
  end

  // R2
  byte_gap_chk: assert property (@(posedge clk) disable iff (rst)
    byte_vld |=> !byte_vld);
endmodule

// File: rtl/rxf_hdr_parse.sv
module rxf_hdr_parse
  import eth_rxf_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sof,
  input  logic             byte_vld,
  input  logic [7:0]       byte_dat,
  output hdr_t             hdr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  int cidx;
  always_comb cidx = int'(cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr <= '0;
      cnt <= '0;
    end else if (sof) begin
      cnt <= '0;
    end else if (byte_vld) begin
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      if (cidx >= OFS_DA && cidx < OFS_DA + 6)
        hdr.da <= {hdr.da[39:0], byte_dat};
      if (cidx >= OFS_ETYPE && cidx < OFS_ETYPE + 2)
        hdr.etype <= {hdr.etype[7:0], byte_dat};
      if (cidx == OFS_PROTO)
        hdr.proto <= byte_dat;
      if (cidx >= OFS_SIP && cidx < OFS_SIP + 4)
        hdr.sip <= {hdr.sip[23:0], byte_dat};
      if (cidx >= OFS_DIP && cidx < OFS_DIP + 4)
        hdr.dip <= {hdr.dip[23:0], byte_dat};
      if (cidx >= OFS_SPORT && cidx < OFS_SPORT + 2)
        hdr.sport <= {hdr.sport[7:0], byte_dat};
      if (cidx >= OFS_DPORT && cidx < OFS_DPORT + 2)
        hdr.dport <= {hdr.dport[7:0], byte_dat};
    end
  end

  // R8
  cnt_mono_chk: assert property (@(posedge clk) disable iff (rst)
    !sof |=> (cnt >= $past(cnt)));
endmodule

// File: rtl/rxf_rule_tbl.sv
module rxf_rule_tbl
  import eth_rxf_pkg::*;
#(
  parameter int N_MCAST = 4,
  parameter int N_RULE  = 4,
  parameter int CFG_AW  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  hdr_t              hdr,
  input  logic              l4_ok,
  output logic              mac_hit,
  output logic              rule_any,
  output logic              rule_pass
);
  localparam int MC_BASE = 2;
  localparam int RL_BASE = MC_BASE + 2 * N_MCAST;
  localparam int IDX_W   = (N_RULE > 1) ? $clog2(N_RULE) : 1;

  logic [47:0]       sta_q;
  logic [N_MCAST-1:0] mc_hit;
  logic [N_RULE-1:0]  rl_hit;
  logic [N_RULE-1:0]  rl_act;
  logic [IDX_W-1:0]   win_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sta_q <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == CFG_AW'(0)) sta_q[31:0]  <= cfg_wdata;
      if (cfg_addr == CFG_AW'(1)) sta_q[47:32] <= cfg_wdata[15:0];
    end
  end

  for (genvar i = 0; i < N_MCAST; i++) begin : g_mc
    logic [47:0] addr_q;
    logic        en_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q <= '0;
        en_q   <= 1'b0;
      end else if (cfg_we) begin
        if (cfg_addr == CFG_AW'(MC_BASE + 2 * i))
          addr_q[31:0] <= cfg_wdata;
        if (cfg_addr == CFG_AW'(MC_BASE + 2 * i + 1)) begin
          addr_q[47:32] <= cfg_wdata[15:0];
          en_q          <= cfg_wdata[16];
        end
      end
    end
    assign mc_hit[i] = en_q && (hdr.da == addr_q);
  end

  for (genvar j = 0; j < N_RULE; j++) begin : g_rule
    logic [31:0] ip_q;
    logic [15:0] port_q;
    rule_ctl_t   ctl_q;
    logic [31:0] ip_cmp;
    logic [15:0] port_cmp;
    always_ff @(posedge clk) begin
      if (rst) begin
        ip_q   <= '0;
        port_q <= '0;
        ctl_q  <= '0;
      end else if (cfg_we) begin
        if (cfg_addr == CFG_AW'(RL_BASE + 3 * j))     ip_q   <= cfg_wdata;
        if (cfg_addr == CFG_AW'(RL_BASE + 3 * j + 1)) port_q <= cfg_wdata[15:0];
        if (cfg_addr == CFG_AW'(RL_BASE + 3 * j + 2)) ctl_q  <= rule_ctl_t'(cfg_wdata[5:0]);
      end
    end
    assign ip_cmp    = ctl_q.ip_dst   ? hdr.dip   : hdr.sip;
    assign port_cmp  = ctl_q.port_dst ? hdr.dport : hdr.sport;
    assign rl_hit[j] = ctl_q.en
                    && (!ctl_q.use_ip   || (ip_q == ip_cmp))
                    && (!ctl_q.use_port || (l4_ok && (port_q == port_cmp)));
    assign rl_act[j] = ctl_q.act_pass;
  end

  always_comb begin
    rule_any  = 1'b0;
    rule_pass = 1'b0;
    win_idx   = '0;
    for (int k = N_RULE - 1; k >= 0; k--) begin
      if (rl_hit[k]) begin
        rule_any  = 1'b1;
        rule_pass = rl_act[k];
        win_idx   = IDX_W'(k);
      end
    end
    mac_hit = (hdr.da == sta_q) || (|mc_hit);
  end

  // R11
  rule_win_chk: assert property (@(posedge clk) disable iff (rst)
    rule_any |-> rl_hit[win_idx]);
endmodule

// File: rtl/eth_rx_filter.sv
module eth_rx_filter
  import eth_rxf_pkg::*;
#(
  parameter int N_MCAST = 4,
  parameter int N_RULE  = 4,
  parameter int CNT_W   = 6,
  parameter int CFG_AW  = $clog2(2 + 2 * N_MCAST + 3 * N_RULE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_dv,
  input  logic              rx_er,
  input  logic [3:0]        rx_nib,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic              verdict_vld,
  output logic              verdict_pass,
  output logic              verdict_err
);
  logic             sof, eof, frm_err, byte_vld;
  logic [7:0]       byte_dat;
  hdr_t             hdr;
  logic [CNT_W-1:0] cnt;
  logic             mac_hit, rule_any, rule_pass;
  logic             is_ipv4, l4_ok, len_ok, pass_c;
  logic [CNT_W-1:0] need_len;

  rxf_nib_asm u_asm (
    .clk(clk), .rst(rst), .rx_dv(rx_dv), .rx_er(rx_er), .rx_nib(rx_nib),
    .sof(sof), .eof(eof), .frm_err(frm_err),
    .byte_vld(byte_vld), .byte_dat(byte_dat)
  );

  rxf_hdr_parse #(.CNT_W(CNT_W)) u_parse (
    .clk(clk), .rst(rst), .sof(sof), .byte_vld(byte_vld),
    .byte_dat(byte_dat), .hdr(hdr), .cnt(cnt)
  );

  rxf_rule_tbl #(.N_MCAST(N_MCAST), .N_RULE(N_RULE), .CFG_AW(CFG_AW)) u_tbl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .hdr(hdr), .l4_ok(l4_ok),
    .mac_hit(mac_hit), .rule_any(rule_any), .rule_pass(rule_pass)
  );

  always_comb begin
    is_ipv4 = (hdr.etype == ETYPE_IPV4);
    l4_ok   = (hdr.proto == PROTO_TCP) || (hdr.proto == PROTO_UDP);
    if (!is_ipv4)   need_len = CNT_W'(LEN_L2);
    else if (l4_ok) need_len = CNT_W'(LEN_L4);
    else            need_len = CNT_W'(LEN_L3);
    len_ok = (cnt >= CNT_W'(LEN_L2)) && (cnt >= need_len);
    pass_c = !frm_err && len_ok && mac_hit
          && (!is_ipv4 || !rule_any || rule_pass);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      verdict_vld  <= 1'b0;
      verdict_pass <= 1'b0;
      verdict_err  <= 1'b0;
    end else begin
      verdict_vld <= eof;
      if (eof) begin
        verdict_pass <= pass_c;
        verdict_err  <= frm_err;
      end
    end
  end

  // R6
  vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    verdict_vld |=> !verdict_vld);
  // R6
  vld_after_eof_chk: assert property (@(posedge clk) disable iff (rst)
    verdict_vld |-> $past(eof));
  // R7
  err_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (eof && frm_err) |=> (verdict_vld && verdict_err && !verdict_pass));
endmodule

// File: tb/tb_eth_rx_filter.sv
module tb_eth_rx_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_dv = 1'b0, rx_er = 1'b0;
  logic [3:0]  rx_nib = '0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        verdict_vld, verdict_pass, verdict_err;
  int nchk = 0, nerr = 0;

  always #5 clk = ~clk;

  eth_rx_filter dut (
    .clk(clk), .rst(rst), .rx_dv(rx_dv), .rx_er(rx_er), .rx_nib(rx_nib),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .verdict_vld(verdict_vld), .verdict_pass(verdict_pass),
    .verdict_err(verdict_err)
  );

  typedef struct packed {
    logic [47:0] da;
    logic [15:0] et;
    logic [7:0]  pr;
    logic [31:0] sip;
    logic [31:0] dip;
    logic [15:0] sp;
    logic [15:0] dp;
    logic [7:0]  len;
    logic [7:0]  pre;
    logic [7:0]  errb;
    logic        xp;
    logic        xe;
  } vec_t;

  localparam logic [47:0] STA = 48'h021122334455;
  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{STA, 16'h0806, 8'd0, 32'h0, 32'h0, 16'd0, 16'd0, 8'd60, 8'd15, 8'hFF, 1'b1, 1'b0},                       // R3
    '{48'h01005E000001, 16'h0806, 8'd0, 32'h0, 32'h0, 16'd0, 16'd0, 8'd60, 8'd15, 8'hFF, 1'b1, 1'b0},          // R4
    '{48'h01005E000002, 16'h0806, 8'd0, 32'h0, 32'h0, 16'd0, 16'd0, 8'd60, 8'd15, 8'hFF, 1'b0, 1'b0},          // R4
    '{48'h021122334456, 16'h0806, 8'd0, 32'h0, 32'h0, 16'd0, 16'd0, 8'd60, 8'd15, 8'hFF, 1'b0, 1'b0},          // R5
    '{STA, 16'h0800, 8'd6,  32'h0A000042, 32'h0A000002, 16'd1024, 16'd80,   8'd60, 8'd15, 8'hFF, 1'b0, 1'b0}, // R9
    '{STA, 16'h0800, 8'd6,  32'h0A000001, 32'h0A000002, 16'd1024, 16'd80,   8'd60, 8'd15, 8'hFF, 1'b1, 1'b0}, // R10
    '{STA, 16'h0800, 8'd17, 32'h0A000001, 32'h0A000002, 16'd23,   16'd9000, 8'd60, 8'd15, 8'hFF, 1'b0, 1'b0}, // R10
    '{STA, 16'h0800, 8'd1,  32'h0A000001, 32'h0A000002, 16'd23,   16'd80,   8'd60, 8'd15, 8'hFF, 1'b1, 1'b0}, // R10
    '{STA, 16'h0800, 8'd6,  32'h0A000001, 32'hC0A80101, 16'd1024, 16'd80,   8'd60, 8'd15, 8'hFF, 1'b1, 1'b0}, // R11
    '{STA, 16'h0800, 8'd6,  32'h0A000001, 32'hC0A80101, 16'd1024, 16'd81,   8'd60, 8'd15, 8'hFF, 1'b0, 1'b0}, // R9
    '{STA, 16'h0800, 8'd17, 32'h0A000001, 32'h0A000005, 16'd1024, 16'd53,   8'd60, 8'd15, 8'hFF, 1'b1, 1'b0}, // R12
    '{STA, 16'h0806, 8'd0,  32'h0, 32'h0, 16'd0, 16'd0, 8'd13, 8'd15, 8'hFF, 1'b0, 1'b0},                      // R8
    '{STA, 16'h0800, 8'd6,  32'h0A000001, 32'h0A000002, 16'd1024, 16'd53,   8'd37, 8'd15, 8'hFF, 1'b0, 1'b0}, // R8
    '{STA, 16'h0800, 8'd1,  32'h0A000001, 32'h0A000002, 16'd0,    16'd0,    8'd34, 8'd15, 8'hFF, 1'b1, 1'b0}, // R8
    '{STA, 16'h0806, 8'd0,  32'h0, 32'h0, 16'd0, 16'd0, 8'd60, 8'd15, 8'd20, 1'b0, 1'b1},                      // R7
    '{STA, 16'h0806, 8'd0,  32'h0, 32'h0, 16'd0, 16'd0, 8'd60, 8'd3,  8'hFF, 1'b1, 1'b0},                      // R2
    '{STA, 16'h0800, 8'd6,  32'h0A000001, 32'h0A000002, 16'd1024, 16'd53,   8'd38, 8'd15, 8'hFF, 1'b1, 1'b0}  // R8
  };

  function automatic string vtag(int k);
    case (k)
      0: return "R3";  1, 2: return "R4";  3: return "R5";
      4: return "R11"; 5, 6, 7: return "R10"; 8: return "R11";
      9: return "R9";  10: return "R12"; 11, 12, 13, 16: return "R8";
      14: return "R7"; 15: return "R2";  default: return "R6";
    endcase
  endfunction

  function automatic logic [7:0] fbyte(vec_t v, int i);
    if (i < 6)              return v.da[47 - 8 * i -: 8];
    if (i < 12)             return 8'hA0 + 8'(i);
    if (i == 12)            return v.et[15:8];
    if (i == 13)            return v.et[7:0];
    if (i == 14)            return 8'h45;
    if (i == 23)            return v.pr;
    if (i >= 26 && i < 30)  return v.sip[31 - 8 * (i - 26) -: 8];
    if (i >= 30 && i < 34)  return v.dip[31 - 8 * (i - 30) -: 8];
    if (i == 34)            return v.sp[15:8];
    if (i == 35)            return v.sp[7:0];
    if (i == 36)            return v.dp[15:8];
    if (i == 37)            return v.dp[7:0];
    return 8'(i);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic put_nib(input logic [3:0] n, input logic e);
    @(negedge clk);
    rx_dv = 1'b1; rx_nib = n; rx_er = e;
  endtask

  task automatic end_burst();
    @(negedge clk);
    rx_dv = 1'b0; rx_nib = '0; rx_er = 1'b0;
  endtask

  task automatic send(input vec_t v);
    logic [7:0] b;
    for (int p = 0; p < int'(v.pre); p++) put_nib(4'h5, 1'b0);
    put_nib(4'hD, 1'b0);
    for (int i = 0; i < int'(v.len); i++) begin
      b = fbyte(v, i);
      put_nib(b[3:0], i == int'(v.errb));
      put_nib(b[7:4], i == int'(v.errb));
    end
    end_burst();
  endtask

  // R6: pulse on the second rising edge with rx_dv low, then gone
  task automatic expect_verdict(input logic xp, input logic xe, input string tag);
    @(posedge clk);
    #1 chk(verdict_vld == 1'b0, {tag, " R6 early"}, verdict_vld, 0);
    @(posedge clk);
    #1;
    chk(verdict_vld == 1'b1, {tag, " R6 valid"}, verdict_vld, 1);
    chk(verdict_pass == xp, {tag, " pass"}, verdict_pass, xp);
    chk(verdict_err == xe, {tag, " err"}, verdict_err, xe);
    @(posedge clk);
    #1 chk(verdict_vld == 1'b0, {tag, " R6 single"}, verdict_vld, 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int seen;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state and quiet idle
    chk(verdict_vld == 0, "R1 vld", verdict_vld, 0);
    chk(verdict_pass == 0, "R1 pass", verdict_pass, 0);
    chk(verdict_err == 0, "R1 err", verdict_err, 0);
    seen = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (verdict_vld) seen++;
    end
    chk(seen == 0, "R1 idle no verdict", seen, 0);

    // R13 table programming
    cfg(0, 32'h22334455);  cfg(1, 32'h0000_0211);
    cfg(2, 32'h5E000001);  cfg(3, 32'h0001_0100);
    cfg(4, 32'h5E000002);  cfg(5, 32'h0000_0100);
    cfg(10, 32'h0A000042); cfg(12, 32'h05);
    cfg(14, 32'd23);       cfg(15, 32'h11);
    cfg(17, 32'd80);       cfg(18, 32'h33);
    cfg(19, 32'hC0A80101); cfg(21, 32'h0D);

    for (int k = 0; k < NV; k++) begin
      send(VEC[k]);
      expect_verdict(VEC[k].xp, VEC[k].xe, $sformatf("%s vec%0d", vtag(k), k));
    end

    // R2: burst without a start nibble is dropped
    for (int p = 0; p < 20; p++) put_nib(4'h5, 1'b0);
    end_burst();
    expect_verdict(1'b0, 1'b0, "R2 no-sfd");

    // R11 R13: disabling rule 0 lets rule 2 decide
    cfg(12, 32'h04);
    send(VEC[4]);
    expect_verdict(1'b1, 1'b0, "R11 disabled rule");

    // R13: rule 3 rewritten as catch-all drop
    cfg(21, 32'h01);
    send(VEC[10]);
    expect_verdict(1'b0, 1'b0, "R13 catch-all");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule